// File: doc/BRIEF.md
# Serial Word Boundary Aligner

This block takes a recovered serial bit stream, one bit per cycle in which `bit_en` is high, and rebuilds the parallel words carried in it. Each frame on the line is 25 bits long. It opens with a single 0 marker bit. The 22 payload bits follow, least significant first. It closes with two boundary bits, and both of them carry the inverse of payload bit 21. Because of that closing rule, every frame holds at least one level transition that falls at a known place.

The aligner does not know where frames start. It tests candidate bit offsets one after another until frames check out repeatedly, and then declares lock. While locked, each good frame is presented as a 22-bit word together with a single-cycle strobe, which downstream logic uses as its recovered pixel clock. If the stream is broken off or slips, lock is lost and the search starts again with no outside help. The transmitter can also command power-down through the link by sending a long run of ones. The block reports this on its own status output and resumes on the first zero that follows.

Top module: `word_aligner`

## Requirements
- R1: Output bit i of `word_out` is the (i+1)-th bit received after the marker, so `word_out[0]` is the first payload bit and `word_out[21]` the last.
- R2: A frame is valid only if its first bit is 0 and both of its last two bits equal the inverse of its payload bit 21. A frame that breaks either rule yields no strobe and leaves `word_out` unchanged.
- R3: While hunting, a frame window that fails the check is followed by a window shifted later by exactly one bit. Alignment is therefore found from any starting offset.
- R4: `locked` rises on the 4th consecutive valid frame at one offset. The first `word_stb` comes with that same frame, and there is no strobe before it.
- R5: While locked, each valid frame produces a `word_stb` high for exactly one clock, together with the new word. `word_out` changes only in a cycle where `word_stb` is high.
- R6: While locked, one or two invalid frames in a row keep lock, give no strobe and hold the word. A valid frame clears the count of invalid frames.
- R7: While locked, a 3rd consecutive invalid frame clears `locked`, holds `word_out` and restarts the hunt, which then locks again on good frames.
- R8: A run of 32 consecutive received 1s sets `pwr_down` on the 32nd one and clears `locked`. A run of 31 ones does not set it. No strobe occurs while `pwr_down` is high.
- R9: The first received 0 while `pwr_down` is high clears `pwr_down`, and that 0 is taken as the marker of the next frame. Lock then follows on the 4th frame.
- R10: A cycle with `bit_en` low consumes no bit, so `bit_in` in that cycle has no effect on the recovered words.
- R11: After reset, `word_out` is 0 and `word_stb`, `locked` and `pwr_down` are all low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_en | input | 1 | High in each cycle that carries a line bit |
| bit_in | input | 1 | Serial line bit, sampled when `bit_en` is high |
| word_out | output | 22 | Last recovered payload word |
| word_stb | output | 1 | One-cycle pulse marking a new `word_out` |
| locked | output | 1 | Frame alignment confirmed |
| pwr_down | output | 1 | In-band power-down command detected |

## Verification
The assertions assume that a strobe can only follow a cycle with `bit_en` high. They also assume that a valid frame never holds more than 21 ones in a row, so a genuine data run cannot be read as a power-down command. The stimulus keeps to this: it builds every good frame with the marker and boundary rule, and it makes long runs of ones only in the deliberate power-down sequences. Corrupted frames, slipped bits and enable gaps are placed at known points, so the expected strobe and lock cycles follow directly from the frame count.

// File: rtl/word_aligner.sv
module word_aligner #(
  parameter int W      = 22,
  parameter int LOCK_N = 4,
  parameter int LOSS_N = 3,
  parameter int PD_RUN = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         bit_en,
  input  logic         bit_in,
  output logic [W-1:0] word_out,
  output logic         word_stb,
  output logic         locked,
  output logic         pwr_down
);
  localparam int FR = W + 3;
  localparam int CW = $clog2(FR);
  localparam int GW = $clog2(LOCK_N + 1);
  localparam int BW = $clog2(LOSS_N + 1);
  localparam int OW = $clog2(PD_RUN + 1);
  localparam logic [CW-1:0] LAST   = CW'(FR - 1);
  localparam logic [GW-1:0] G_LAST = GW'(LOCK_N - 1);
  localparam logic [BW-1:0] B_LAST = BW'(LOSS_N - 1);
  localparam logic [OW-1:0] O_MAX  = OW'(PD_RUN);
  localparam logic [OW-1:0] O_HIT  = OW'(PD_RUN - 1);

  logic [FR-1:0] sr;
  logic [CW-1:0] cnt;
  logic [GW-1:0] good;
  logic [BW-1:0] bad;
  logic [OW-1:0] ones;

  wire [FR-1:0] frm     = {bit_in, sr[FR-1:1]};
  wire          frm_ok  = ~frm[0] & (frm[FR-1] == ~frm[W]) & (frm[FR-2] == ~frm[W]);
  wire          run_hit = bit_in & (ones == O_HIT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sr       <= '0;
      cnt      <= '0;
      good     <= '0;
      bad      <= '0;
      ones     <= '0;
      word_out <= '0;
      word_stb <= 1'b0;
      locked   <= 1'b0;
      pwr_down <= 1'b0;
    end else begin
      word_stb <= 1'b0;
      if (bit_en) begin
        sr <= frm;
        if (!bit_in)            ones <= '0;
        else if (ones != O_MAX) ones <= ones + 1'b1;

        if (pwr_down) begin
          if (!bit_in) begin
            pwr_down <= 1'b0;
            cnt      <= CW'(1);
          end
        end else if (run_hit) begin
          pwr_down <= 1'b1;
          locked   <= 1'b0;
          good     <= '0;
          bad      <= '0;
        end else if (cnt != LAST) begin
          cnt <= cnt + 1'b1;
        end else if (!locked) begin
          if (frm_ok) begin
            cnt <= '0;
            if (good == G_LAST) begin
              locked   <= 1'b1;
              good     <= '0;
              bad      <= '0;
              word_out <= frm[W:1];
              word_stb <= 1'b1;
            end else begin
              good <= good + 1'b1;
            end
          end else begin
            good <= '0;
          end
        end else if (frm_ok) begin
          cnt      <= '0;
          bad      <= '0;
          word_out <= frm[W:1];
          word_stb <= 1'b1;
        end else if (bad == B_LAST) begin
          locked <= 1'b0;
          bad    <= '0;
          good   <= '0;
        end else begin
          bad <= bad + 1'b1;
          cnt <= '0;
        end
      end
    end
  end
endmodule

// File: rtl/word_aligner_chk.sv
module word_aligner_chk #(
  parameter int W = 22
) (
  input logic         clk,
  input logic         rst_n,
  input logic         bit_en,
  input logic         bit_in,
  input logic [W-1:0] word_out,
  input logic         word_stb,
  input logic         locked,
  input logic         pwr_down
);
  AST_STB_NEEDS_LOCK: assert property (@(posedge clk) disable iff (!rst_n) word_stb |-> locked); // R4
  AST_LOCK_WITH_STB: assert property (@(posedge clk) disable iff (!rst_n) $rose(locked) |-> word_stb); // R4
  AST_WORD_HELD: assert property (@(posedge clk) disable iff (!rst_n) !word_stb |-> $stable(word_out)); // R5
  AST_STB_AFTER_BIT: assert property (@(posedge clk) disable iff (!rst_n) word_stb |-> $past(bit_en)); // R10
  AST_STB_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n) word_stb |-> (word_out[W-1] == ~$past(bit_in))); // R2
  AST_PD_NO_LOCK: assert property (@(posedge clk) disable iff (!rst_n) pwr_down |-> !locked); // R8
  AST_PD_NO_STB: assert property (@(posedge clk) disable iff (!rst_n) pwr_down |-> !word_stb); // R8
  AST_PD_RELEASE: assert property (@(posedge clk) disable iff (!rst_n) $fell(pwr_down) |-> $past(bit_en && !bit_in)); // R9
  AST_PD_ON_ONE: assert property (@(posedge clk) disable iff (!rst_n) $rose(pwr_down) |-> $past(bit_en && bit_in)); // R8
endmodule

bind word_aligner word_aligner_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .bit_in(bit_in),
  .word_out(word_out), .word_stb(word_stb), .locked(locked), .pwr_down(pwr_down)
);

// File: tb/sim_word_aligner.sv
`timescale 1ns/100ps
module sim_word_aligner;
  logic clk = 1'b0, rst_n = 1'b0, bit_en = 1'b0, bit_in = 1'b0;
  logic [21:0] word_out;
  logic word_stb, locked, pwr_down;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;
  bit f_stb;
  logic [21:0] f_word;

  always #2.5 clk = ~clk;

  word_aligner u0 (.clk(clk), .rst_n(rst_n), .bit_en(bit_en), .bit_in(bit_in),
                   .word_out(word_out), .word_stb(word_stb), .locked(locked), .pwr_down(pwr_down));

  // {expected strobe/lock after frame, payload}
  localparam logic [22:0] VEC [8] = '{
    {1'b0, 22'h2AB3C1}, {1'b0, 22'h15CE0F}, {1'b0, 22'h000001}, {1'b1, 22'h3FFFFE},
    {1'b1, 22'h1F00F0}, {1'b1, 22'h200000}, {1'b1, 22'h0A5A5A}, {1'b1, 22'h35C3A7}};

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send_bit(bit b);
    @(negedge clk); bit_en = 1'b1; bit_in = b;
    @(posedge clk); #1;
    if (word_stb) begin f_stb = 1'b1; f_word = word_out; end
  endtask

  task automatic gap(bit b);
    @(negedge clk); bit_en = 1'b0; bit_in = b;
    @(posedge clk); #1;
    if (word_stb) begin f_stb = 1'b1; f_word = word_out; end
  endtask

  task automatic send_frame(logic [21:0] w, bit mk, bit bflip, bit gaps);
    logic [24:0] f;
    f = {~w[21], ~w[21] ^ bflip, w, mk};
    f_stb = 1'b0;
    for (int i = 0; i < 25; i++) begin
      if (gaps && (i % 3 == 0)) gap(~f[i]);
      send_bit(f[i]);
    end
  endtask

  function automatic logic [21:0] pat(int i);
    return 22'((i * 32'h1A2B3) + 32'h05F1D);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [21:0] held;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    check(word_out == 0 && !word_stb && !locked && !pwr_down, "R11 reset",
          {word_out, word_stb, locked, pwr_down}, 0);

    for (int k = 0; k < 8; k++) begin
      send_frame(VEC[k][21:0], 1'b0, 1'b0, 1'b0);
      check(f_stb == VEC[k][22], "R4 strobe onset", f_stb, VEC[k][22]);
      check(locked == VEC[k][22], "R4 lock onset", locked, VEC[k][22]);
      if (VEC[k][22]) check(f_word == VEC[k][21:0], "R1 R5 word", f_word, VEC[k][21:0]);
    end

    held = word_out;
    send_frame(22'h123456, 1'b0, 1'b1, 1'b0);
    check(!f_stb && word_out == held, "R2 boundary mismatch", word_out, held);
    send_frame(22'h0F0F0F, 1'b0, 1'b0, 1'b0);
    check(f_stb && f_word == 22'h0F0F0F, "R6 valid resets count", f_word, 22'h0F0F0F);
    send_frame(22'h222222, 1'b1, 1'b0, 1'b0);
    check(!f_stb && word_out == 22'h0F0F0F, "R2 marker high", word_out, 22'h0F0F0F);
    send_frame(22'h333333, 1'b0, 1'b1, 1'b0);
    check(locked && word_out == 22'h0F0F0F, "R6 two bad keep lock", {locked, word_out}, {1'b1, 22'h0F0F0F});
    send_frame(22'h3C3C3C, 1'b0, 1'b0, 1'b0);
    check(f_stb && f_word == 22'h3C3C3C, "R6 recover", f_word, 22'h3C3C3C);
    send_frame(22'h111111, 1'b1, 1'b0, 1'b0);
    send_frame(22'h111111, 1'b1, 1'b0, 1'b0);
    send_frame(22'h2468AC, 1'b0, 1'b0, 1'b0);
    check(locked && f_stb && f_word == 22'h2468AC, "R6 count cleared", f_word, 22'h2468AC);

    send_frame(22'h1ACE55, 1'b0, 1'b0, 1'b1);
    check(f_stb && f_word == 22'h1ACE55, "R10 enable gaps", f_word, 22'h1ACE55);

    send_frame(22'h010101, 1'b1, 1'b0, 1'b0);
    send_frame(22'h020202, 1'b1, 1'b0, 1'b0);
    check(locked, "R7 lock after two bad", locked, 1);
    send_frame(22'h030303, 1'b1, 1'b0, 1'b0);
    check(!locked && word_out == 22'h1ACE55, "R7 loss", {locked, word_out}, {1'b0, 22'h1ACE55});
    for (int k = 0; k < 12; k++) send_frame(pat(k), 1'b0, 1'b0, 1'b0);
    check(locked && f_stb && f_word == pat(11), "R7 relock", f_word, pat(11));

    for (int k = 0; k < 7; k++) send_bit(k[0]);
    for (int k = 20; k < 34; k++) send_frame(pat(k), 1'b0, 1'b0, 1'b0);
    check(locked && f_stb && f_word == pat(33), "R3 realign after slip", f_word, pat(33));

    send_frame(22'h2ABCDE, 1'b0, 1'b0, 1'b0);
    for (int k = 0; k < 31; k++) send_bit(1'b1);
    check(!pwr_down && locked, "R8 31 ones", {pwr_down, locked}, 2'b01);
    send_bit(1'b1);
    check(pwr_down && !locked, "R8 32 ones", {pwr_down, locked}, 2'b10);
    f_stb = 1'b0;
    for (int k = 0; k < 10; k++) send_bit(1'b1);
    check(pwr_down && !f_stb && word_out == 22'h2ABCDE, "R8 hold", word_out, 22'h2ABCDE);
    for (int k = 0; k < 4; k++) begin
      send_frame(pat(40 + k), 1'b0, 1'b0, 1'b0);
      if (k == 0) check(!pwr_down, "R9 release", pwr_down, 0);
      check(f_stb == (k == 3), "R9 lock after resume", f_stb, (k == 3));
    end
    check(f_word == pat(43), "R9 word", f_word, pat(43));

    @(negedge clk); bit_en = 1'b0;
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule